// File: doc/BRIEF.md
# Doubleword Transfer Sequencer

This block sits between a 32-bit memory data bus and a file of sixteen 64-bit registers. Each register is held as an upper half and a lower half. A transfer begins with a start strobe. The strobe carries the instruction word, the transfer direction, the transfer length (one word or two), the data type (integer or floating point) and the current byte order. Data beats then arrive one at a time. On a load, the sequencer turns each beat into writes on the register-file write port. On a store, it drives the matching register half onto the store data bus in the same cycle as the beat.

For a two-word transfer, a one-bit beat counter selects the register half. The byte-order input decides which half comes first. For a single-word transfer, the data type alone picks the half. A single-word integer load is widened with its sign, so it fills the whole 64-bit register. One cycle after the final accepted beat, a done pulse is raised. Beats that are not marked as data are dropped.

Top module: `xfer_seq`

## Requirements
- R1: After reset the block is idle: both write enables are 0, the store data is 0, done is 0 and the register index output is 0.
- R2: On a start strobe the register index is captured from instruction bits 15:12. It is presented on `rf_idx` for the whole transfer, for both writes and reads.
- R3: A two-word transfer started with `big_endian`=1 maps its first accepted beat to the upper half and its second to the lower half.
- R4: A two-word transfer started with `big_endian`=0 maps its first accepted beat to the lower half and its second to the upper half.
- R5: A single-word load with `xfer_int`=0 (floating point) writes only the upper half with the beat data.
- R6: A single-word load with `xfer_int`=1 writes the beat data to the lower half and writes copies of its bit 31 to every bit of the upper half, both in the same cycle.
- R7: On a store, `st_data` equals the selected half (`rd_hi` or `rd_lo`) in the cycle of each accepted beat. The half is picked as in R3/R4 for two-word transfers, as upper for a single float and as lower for a single integer. No write enable rises during a store.
- R8: A beat with `beat_is_data`=0, or any beat while no transfer is active, is ignored. It causes no write and no store data, and it does not advance the beat count.
- R9: `done` is high for exactly one cycle, in the cycle after the final accepted beat. The block is then idle and ignores further beats.
- R10: Outside an accepted store beat, `st_data` is 0.
- R11: A start strobe during an active transfer abandons it. The beat count restarts with the new attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Transfer start strobe, one cycle |
| xfer_instr | input | 32 | Instruction word; bits 15:12 name the register |
| xfer_store | input | 1 | 1 = store (register to bus), 0 = load |
| xfer_double | input | 1 | 1 = two-word transfer |
| xfer_int | input | 1 | 1 = integer data type, 0 = floating point |
| big_endian | input | 1 | Byte order for two-word transfers |
| beat_strobe | input | 1 | A bus beat is present |
| beat_is_data | input | 1 | The beat is a data beat |
| mem_rdata | input | 32 | Load data from the bus |
| rd_hi | input | 32 | Upper half of register `rf_idx` |
| rd_lo | input | 32 | Lower half of register `rf_idx` |
| rf_idx | output | 4 | Register index for write and read |
| rf_we_hi | output | 1 | Write enable, upper half |
| rf_we_lo | output | 1 | Write enable, lower half |
| rf_wd_hi | output | 32 | Write data, upper half |
| rf_wd_lo | output | 32 | Write data, lower half |
| st_data | output | 32 | Store data to the bus |
| done | output | 1 | Transfer-complete pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, 16 registers and the index field at bit 12. At these values every register index and both sign polarities of the integer widening can be reached. Random transfers mix both directions, both lengths, both data types and both byte orders with dropped non-data beats, idle beats and restarts in mid-transfer. Directed cases pin down each half ordering, a negative integer load and a restart.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    // Half chosen for a beat: two-word order by byte order and beat number,
    // single word by data type (float -> upper, integer -> lower).
    function automatic half_e pick_half(input logic dbl, input logic is_int,
                                        input logic big, input logic second);
        if (dbl)
            return (second ^ big) ? HALF_HI : HALF_LO;
        return is_int ? HALF_LO : HALF_HI;
    endfunction
endpackage

// File: rtl/xseq_ctrl.sv
module xseq_ctrl #(
    parameter int INSTR_W = 32,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [INSTR_W-1:0] instr,
    input  logic             store_in,
    input  logic             dbl_in,
    input  logic             int_in,
    input  logic             big_in,
    input  logic             beat_strobe,
    input  logic             beat_is_data,
    output logic             accept,
    output logic             store,
    output logic             dbl,
    output logic             is_int,
    output logic             big,
    output logic             second,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic             store;
        logic             dbl;
        logic             is_int;
        logic             big;
        logic             second;
        logic             done;
        logic [IDX_W-1:0] idx;
    } ctl_s;

    ctl_s st_d, st_q;
    logic last_beat;
    logic instr_unused;

    assign instr_unused = ^{instr[INSTR_W-1:IDX_LSB+IDX_W], instr[IDX_LSB-1:0]};

    assign accept    = st_q.busy && beat_strobe && beat_is_data;
    assign last_beat = !st_q.dbl || st_q.second;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.busy   = 1'b1;
            st_d.store  = store_in;
            st_d.dbl    = dbl_in;
            st_d.is_int = int_in;
            st_d.big    = big_in;
            st_d.second = 1'b0;
            st_d.idx    = instr[IDX_LSB +: IDX_W];
        end else if (accept) begin
            if (last_beat) begin
                st_d.busy   = 1'b0;
                st_d.second = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.second = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign store  = st_q.store;
    assign dbl    = st_q.dbl;
    assign is_int = st_q.is_int;
    assign big    = st_q.big;
    assign second = st_q.second;
    assign idx    = st_q.idx;
    assign done   = st_q.done;

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);
    p_second_in_dbl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.second |-> (st_q.busy && st_q.dbl));
    p_restart_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.busy && !st_q.second));
endmodule

// File: rtl/xseq_route.sv
module xseq_route
    import xseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              store,
    input  logic              dbl,
    input  logic              is_int,
    input  logic              big,
    input  logic              second,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] rd_hi,
    input  logic [DATA_W-1:0] rd_lo,
    output logic              we_hi,
    output logic              we_lo,
    output logic [DATA_W-1:0] wd_hi,
    output logic [DATA_W-1:0] wd_lo,
    output logic [DATA_W-1:0] st_data
);
    half_e sel;
    logic  widen;

    assign sel   = pick_half(dbl, is_int, big, second);
    assign widen = !dbl && is_int;

    always_comb begin
        we_hi   = 1'b0;
        we_lo   = 1'b0;
        wd_hi   = mem_rdata;
        wd_lo   = mem_rdata;
        st_data = '0;
        if (accept) begin
            if (store) begin
                st_data = (sel == HALF_HI) ? rd_hi : rd_lo;
            end else if (widen) begin
                we_hi = 1'b1;
                we_lo = 1'b1;
                wd_hi = {DATA_W{mem_rdata[DATA_W-1]}};
            end else begin
                we_hi = (sel == HALF_HI);
                we_lo = (sel == HALF_LO);
            end
        end
    end

    p_store_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> !(we_hi || we_lo));
    p_float_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !store && !dbl && !is_int) |-> (we_hi && !we_lo));
    p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi && we_lo) |-> (wd_hi == {DATA_W{mem_rdata[DATA_W-1]}}));
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> (!we_hi && !we_lo && st_data == '0));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq #(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32,
    parameter int REG_CNT = 16,
    parameter int IDX_LSB = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       xfer_start,
    input  logic [INSTR_W-1:0]         xfer_instr,
    input  logic                       xfer_store,
    input  logic                       xfer_double,
    input  logic                       xfer_int,
    input  logic                       big_endian,
    input  logic                       beat_strobe,
    input  logic                       beat_is_data,
    input  logic [DATA_W-1:0]          mem_rdata,
    input  logic [DATA_W-1:0]          rd_hi,
    input  logic [DATA_W-1:0]          rd_lo,
    output logic [$clog2(REG_CNT)-1:0] rf_idx,
    output logic                       rf_we_hi,
    output logic                       rf_we_lo,
    output logic [DATA_W-1:0]          rf_wd_hi,
    output logic [DATA_W-1:0]          rf_wd_lo,
    output logic [DATA_W-1:0]          st_data,
    output logic                       done
);
    localparam int IDX_W = $clog2(REG_CNT);

    logic accept, store, dbl, is_int, big, second;

    xseq_ctrl #(.INSTR_W(INSTR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .instr(xfer_instr),
        .store_in(xfer_store), .dbl_in(xfer_double), .int_in(xfer_int),
        .big_in(big_endian), .beat_strobe(beat_strobe), .beat_is_data(beat_is_data),
        .accept(accept), .store(store), .dbl(dbl), .is_int(is_int), .big(big),
        .second(second), .idx(rf_idx), .done(done)
    );

    xseq_route #(.DATA_W(DATA_W)) u_route (
        .clk(clk), .rst_n(rst_n), .accept(accept), .store(store), .dbl(dbl),
        .is_int(is_int), .big(big), .second(second), .mem_rdata(mem_rdata),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .we_hi(rf_we_hi), .we_lo(rf_we_lo),
        .wd_hi(rf_wd_hi), .wd_lo(rf_wd_lo), .st_data(st_data)
    );
endmodule

// File: tb/xfer_seq_test.sv
`timescale 1ns/1ps
module xfer_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_store = 1'b0, xfer_double = 1'b0;
    logic        xfer_int = 1'b0, big_endian = 1'b0;
    logic        beat_strobe = 1'b0, beat_is_data = 1'b0;
    logic [31:0] xfer_instr = '0, mem_rdata = '0, rd_hi = '0, rd_lo = '0;
    logic [3:0]  rf_idx;
    logic        rf_we_hi, rf_we_lo, done;
    logic [31:0] rf_wd_hi, rf_wd_lo, st_data;

    always #2.5 clk = ~clk;

    xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_instr(xfer_instr),
        .xfer_store(xfer_store), .xfer_double(xfer_double), .xfer_int(xfer_int),
        .big_endian(big_endian), .beat_strobe(beat_strobe), .beat_is_data(beat_is_data),
        .mem_rdata(mem_rdata), .rd_hi(rd_hi), .rd_lo(rd_lo), .rf_idx(rf_idx),
        .rf_we_hi(rf_we_hi), .rf_we_lo(rf_we_lo), .rf_wd_hi(rf_wd_hi),
        .rf_wd_lo(rf_wd_lo), .st_data(st_data), .done(done)
    );

    int    checks = 0, errors = 0;
    string note = "";

    // Reference state, updated from the requirements at each clock edge
    logic       m_busy = 0, m_store = 0, m_dbl = 0, m_int = 0, m_big = 0;
    logic       m_second = 0, m_done = 0;
    logic [3:0] m_idx = '0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s%s %s actual=%h expected=%h", tag, note, what, act, exp);
        end
    endtask

    function automatic logic exp_hi_half(input logic dbl, input logic is_int,
                                         input logic big, input logic second);
        if (dbl) return big ? !second : second;   // R3 / R4
        return !is_int;                            // float upper, integer lower
    endfunction

    task automatic cyc(input logic st, input logic [31:0] ins, input logic sto,
                       input logic dbl, input logic itp, input logic big,
                       input logic bs, input logic bd, input logic [31:0] data);
        logic  acc, hs;
        string tag;
        @(negedge clk);
        xfer_start = st; xfer_instr = ins; xfer_store = sto; xfer_double = dbl;
        xfer_int = itp; big_endian = big; beat_strobe = bs; beat_is_data = bd;
        mem_rdata = data; rd_hi = $urandom; rd_lo = $urandom;
        #1;
        acc = m_busy && bs && bd;
        hs  = exp_hi_half(m_dbl, m_int, m_big, m_second);
        tag = m_dbl ? (m_big ? "R3" : "R4") : (m_int ? "R6" : "R5");
        if (acc && !m_store) begin
            if (!m_dbl && m_int) begin
                chk("R6", "we_hi", rf_we_hi, 1); chk("R6", "we_lo", rf_we_lo, 1);
                chk("R6", "wd_lo", rf_wd_lo, data);
                chk("R6", "wd_hi", rf_wd_hi, {32{data[31]}});
            end else begin
                chk(tag, "we_hi", rf_we_hi, hs); chk(tag, "we_lo", rf_we_lo, !hs);
                chk(tag, "wdata", hs ? rf_wd_hi : rf_wd_lo, data);
            end
            chk("R10", "st_data", st_data, 0);
        end else begin
            chk(acc ? "R7" : "R8", "we_hi", rf_we_hi, 0);
            chk(acc ? "R7" : "R8", "we_lo", rf_we_lo, 0);
            if (acc) chk("R7", "st_data", st_data, hs ? rd_hi : rd_lo);
            else     chk("R10", "st_data", st_data, 0);
        end
        chk("R9", "done", done, m_done);
        if (m_busy) chk("R2", "rf_idx", rf_idx, m_idx);
        m_done = 0;
        if (st) begin
            m_busy = 1; m_store = sto; m_dbl = dbl; m_int = itp; m_big = big;
            m_second = 0; m_idx = ins[15:12];
        end else if (acc) begin
            if (!m_dbl || m_second) begin
                m_busy = 0; m_second = 0; m_done = 1;
            end else m_second = 1;
        end
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic beat(input logic [31:0] d);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, d);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "we_hi", rf_we_hi, 0); chk("R1", "we_lo", rf_we_lo, 0);
        chk("R1", "st_data", st_data, 0); chk("R1", "done", done, 0);
        chk("R1", "rf_idx", rf_idx, 0);
        rst_n = 1'b1;
        idle();
        // R3 big-endian two-word load, register 9
        cyc(1, 32'h0000_9000, 0, 1, 0, 1, 0, 0, 0);
        beat(32'h1111_1111); beat(32'h2222_2222); idle();
        // R4 little-endian two-word load with a dropped non-data beat (R8)
        cyc(1, 32'h0000_3000, 0, 1, 1, 0, 0, 0, 0);
        beat(32'hAAAA_0001);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'hDEAD_BEEF);
        beat(32'hAAAA_0002); idle();
        // R5 float load, R6 negative and positive integer loads
        cyc(1, 32'h0000_F000, 0, 0, 0, 0, 0, 0, 0); beat(32'h3F80_0000);
        cyc(1, 32'h0000_1000, 0, 0, 1, 0, 0, 0, 0); beat(32'h8000_0005);
        cyc(1, 32'h0000_2000, 0, 0, 1, 0, 0, 0, 0); beat(32'h7FFF_FFFF);
        // R7 stores: float single, integer single, two-word both orders
        cyc(1, 32'h0000_4000, 1, 0, 0, 0, 0, 0, 0); beat(0);
        cyc(1, 32'h0000_5000, 1, 0, 1, 0, 0, 0, 0); beat(0);
        cyc(1, 32'h0000_6000, 1, 1, 0, 1, 0, 0, 0); beat(0); beat(0);
        cyc(1, 32'h0000_7000, 1, 1, 0, 0, 0, 0, 0); beat(0); beat(0);
        // R8/R9 beats while idle are ignored
        beat(32'h1234_5678); beat(32'h8765_4321);
        // R11 restart mid-transfer
        note = " R11";
        cyc(1, 32'h0000_8000, 0, 1, 0, 1, 0, 0, 0); beat(32'h0101_0101);
        cyc(1, 32'h0000_C000, 0, 1, 0, 0, 0, 0, 0);
        beat(32'h0202_0202); beat(32'h0303_0303); idle();
        note = "";
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic st;
            st = (!m_busy && ($urandom % 3 == 0)) || ($urandom % 23 == 0);
            cyc(st, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), ($urandom % 4) != 0, $urandom);
        end
        idle(); idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule